// File: doc/BRIEF.md
# Decimal Character Compressor for a Byte Link

This block turns a stream of received text characters into a compact decimal stream for a byte-wide link. Each character between '0' and '9' becomes a 4-bit decimal value. Every three values form a 12-bit group, which goes to an external densely packed decimal encoder. The encoder returns a 10-bit code. The block then cuts those codes into 8-bit bytes for a byte transmitter. Any other character is dropped.

An end-of-message pulse closes the message. If one or two digits are still waiting, they are completed with zero digits and encoded. Any leftover code bits go out in a final byte, padded with zeros. The block then starts the next message from an empty state. When the transmitter does not take bytes, the stall propagates back to the input handshake.

Top module: `digit_dpd_packer`

## Requirements
- R1: An input byte with value 0x30 to 0x39 is a digit whose value is the byte's low four bits. Three accepted digits form one group on `enc_bcd`, with the first digit in bits 11:8, the second in bits 7:4 and the third in bits 3:0.
- R2: The 10-bit code on `enc_dpd` for each group is appended once to the output bit stream. `enc_bcd` holds steady until the code has been taken.
- R3: An accepted byte outside 0x30 to 0x39 does not change the digit count or the partial group.
- R4: An end-of-message with one or two digits waiting fills the missing lower digit positions with zero and encodes the group.
- R5: Codes are sent most significant bit first. The first code bit goes to bit 7 of the first byte, and a byte is produced as soon as 8 bits are pending.
- R6: At end of message, remaining bits fewer than 8 are sent as one byte, left-aligned, with zeros in the low bits. An end-of-message with nothing pending produces no byte.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R8: `in_ready` falls when a completed group cannot be taken because 8 or more bits wait behind a stalled output. It also stays low while an end-of-message is being drained.
- R9: After an end-of-message has drained, the next message starts with no digits and no pending bits.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A received byte is present |
| in_byte | input | 8 | Received character |
| in_eom | input | 1 | End of message, taken in a cycle where `in_ready` is high |
| in_ready | output | 1 | Block accepts a byte or an end-of-message this cycle |
| enc_bcd | output | 12 | Three-digit decimal group sent to the encoder |
| enc_dpd | input | 10 | Encoder result for `enc_bcd`, returned in the same cycle |
| out_valid | output | 1 | Output byte is present |
| out_data | output | 8 | Packed byte for the transmitter |
| out_ready | input | 1 | Transmitter takes the byte |

## Verification
The assertions assume that `enc_dpd` is a pure combinational function of `enc_bcd` within the same cycle, and that an end-of-message counts only in a cycle where `in_ready` is high. The stimulus keeps to these assumptions in two ways. The bench's encoder model is driven straight from `enc_bcd`. Every byte and every end-of-message is held until a sample shows `in_ready` high. `out_ready` may follow any pattern, so the bench runs with it always high, alternating, and held low for long stretches.

// File: rtl/dpd_pack_pkg.sv
package dpd_pack_pkg;
  localparam int unsigned DIGIT_CODE_LO = 48;
  localparam int unsigned DIGIT_CODE_HI = 57;

  function automatic logic char_is_digit(input logic [7:0] ch);
    return (32'(ch) >= DIGIT_CODE_LO) && (32'(ch) <= DIGIT_CODE_HI);
  endfunction
endpackage

// File: rtl/digit_grouper.sv
module digit_grouper
  import dpd_pack_pkg::*;
#(
  parameter int NIB_W      = 4,
  parameter int GRP_DIGITS = 3,
  parameter int BYTE_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [BYTE_W-1:0]           in_byte,
  input  logic                        in_eom,
  output logic                        in_ready,
  output logic [NIB_W*GRP_DIGITS-1:0] grp,
  output logic                        grp_valid,
  input  logic                        grp_take,
  output logic                        flush_req,
  input  logic                        drained
);
  localparam int GRP_W = NIB_W * GRP_DIGITS;
  localparam int CNT_W = $clog2(GRP_DIGITS + 1);

  logic [CNT_W-1:0] nib_cnt, n_next;
  logic [GRP_W-1:0] part, part_next, aligned;
  logic             flush_pend, take_dig, take_eom, close;

  assign in_ready  = !grp_valid && !flush_pend;
  assign flush_req = flush_pend && !grp_valid;
  assign take_dig  = in_valid && in_ready && char_is_digit(8'(in_byte));
  assign take_eom  = in_eom && in_ready;

  always_comb begin
    n_next    = nib_cnt + CNT_W'(take_dig);
    part_next = take_dig ? {part[GRP_W-NIB_W-1:0], in_byte[NIB_W-1:0]} : part;
    aligned   = part_next << (NIB_W * (GRP_DIGITS - 32'(n_next)));
    close     = (n_next == CNT_W'(GRP_DIGITS)) || (take_eom && n_next != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nib_cnt    <= '0;
      part       <= '0;
      grp        <= '0;
      grp_valid  <= 1'b0;
      flush_pend <= 1'b0;
    end else begin
      if (grp_take) grp_valid <= 1'b0;
      if (close) begin
        grp       <= aligned;
        grp_valid <= 1'b1;
        nib_cnt   <= '0;
        part      <= '0;
      end else begin
        nib_cnt <= n_next;
        part    <= part_next;
      end
      if (take_eom)
        flush_pend <= 1'b1;
      else if (flush_pend && !grp_valid && drained)
        flush_pend <= 1'b0;
    end
  end

  // R1: a full group is always released, so the count never rests at the group size
  assert_nib_bound_R1: assert property (@(posedge clk) disable iff (rst)
    nib_cnt < CNT_W'(GRP_DIGITS));

  // R2: a group waiting for the packer is held unchanged
  assert_grp_hold_R2: assert property (@(posedge clk) disable iff (rst)
    grp_valid && !grp_take |=> grp_valid && $stable(grp));

  // R9: the end of a drain leaves no digits and no group behind
  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(flush_pend) |-> nib_cnt == '0 && !grp_valid);
endmodule

// File: rtl/declet_packer.sv
module declet_packer #(
  parameter int BYTE_W = 8,
  parameter int DEC_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DEC_W-1:0]  dec,
  input  logic              grp_valid,
  output logic              grp_take,
  input  logic              flush_req,
  output logic              drained,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready
);
  localparam int ACC_W = DEC_W + BYTE_W - 1;
  localparam int CNT_W = $clog2(ACC_W + 1);
  localparam logic [CNT_W-1:0] BYTE_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] DEC_CNT  = CNT_W'(DEC_W);

  logic [ACC_W-1:0]  acc;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] hi_byte, pad_byte;
  logic              can_load, full;

  assign full     = cnt >= BYTE_CNT;
  assign can_load = !out_valid || out_ready;
  assign grp_take = grp_valid && !full;
  assign drained  = cnt == '0;

  always_comb begin
    hi_byte  = BYTE_W'(acc >> (cnt - BYTE_CNT));
    pad_byte = BYTE_W'(acc << (BYTE_CNT - cnt));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (can_load && full) begin
        out_data  <= hi_byte;
        out_valid <= 1'b1;
        cnt       <= cnt - BYTE_CNT;
      end else if (can_load && flush_req && !drained) begin
        out_data  <= pad_byte;
        out_valid <= 1'b1;
        cnt       <= '0;
        acc       <= '0;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (grp_take) begin
        acc <= (acc << DEC_W) | ACC_W'(dec);
        cnt <= cnt + DEC_CNT;
      end
    end
  end

  // R7: a byte on offer stays put until the transmitter takes it
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R5: pending bits never exceed what the accumulator holds
  assert_acc_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(ACC_W));

  // R6: once the drain starts, no fresh code is appended
  assert_no_append_in_flush_R6: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> !grp_take);
endmodule

// File: rtl/digit_dpd_packer.sv
module digit_dpd_packer #(
  parameter int BYTE_W     = 8,
  parameter int NIB_W      = 4,
  parameter int GRP_DIGITS = 3,
  parameter int DEC_W      = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [BYTE_W-1:0]           in_byte,
  input  logic                        in_eom,
  output logic                        in_ready,
  output logic [NIB_W*GRP_DIGITS-1:0] enc_bcd,
  input  logic [DEC_W-1:0]            enc_dpd,
  output logic                        out_valid,
  output logic [BYTE_W-1:0]           out_data,
  input  logic                        out_ready
);
  logic grp_valid, grp_take, flush_req, drained;

  digit_grouper #(.NIB_W(NIB_W), .GRP_DIGITS(GRP_DIGITS), .BYTE_W(BYTE_W)) u_group (
    .clk, .rst, .in_valid, .in_byte, .in_eom, .in_ready,
    .grp(enc_bcd), .grp_valid, .grp_take, .flush_req, .drained
  );

  declet_packer #(.BYTE_W(BYTE_W), .DEC_W(DEC_W)) u_pack (
    .clk, .rst, .dec(enc_dpd), .grp_valid, .grp_take, .flush_req, .drained,
    .out_valid, .out_data, .out_ready
  );
endmodule

// File: tb/test_digit_dpd_packer.sv
module test_digit_dpd_packer;
  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_eom = 1'b0, out_ready = 1'b1;
  logic [7:0] in_byte = '0;
  logic [11:0] enc_bcd;
  logic [9:0]  enc_dpd;
  logic out_valid, in_ready;
  logic [7:0] out_data;
  int n_chk = 0, n_bad = 0, cyc = 0, rdy_mode = 0;
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  digit_dpd_packer i_digit_dpd_packer (
    .clk, .rst, .in_valid, .in_byte, .in_eom, .in_ready,
    .enc_bcd, .enc_dpd, .out_valid, .out_data, .out_ready
  );

  function automatic logic [9:0] dpd_enc(input logic [11:0] b);
    logic a, bb, c, d, e, f, g, h, i, j, k, m;
    {a, bb, c, d, e, f, g, h, i, j, k, m} = b;
    case ({a, e, i})
      3'b000: return {bb, c, d, f, g, h, 1'b0, j, k, m};
      3'b001: return {bb, c, d, f, g, h, 1'b1, 2'b00, m};
      3'b010: return {bb, c, d, j, k, h, 1'b1, 2'b01, m};
      3'b100: return {j, k, d, f, g, h, 1'b1, 2'b10, m};
      3'b110: return {j, k, d, 2'b00, h, 1'b1, 2'b11, m};
      3'b101: return {f, g, d, 2'b01, h, 1'b1, 2'b11, m};
      3'b011: return {bb, c, d, 2'b10, h, 1'b1, 2'b11, m};
      default: return {2'b00, d, 2'b11, h, 1'b1, 2'b11, m};
    endcase
  endfunction

  assign enc_dpd = dpd_enc(enc_bcd);

  // {group, known code} pairs
  localparam logic [21:0] VEC [9] = '{
    {12'h005, 10'h005}, {12'h009, 10'h009}, {12'h055, 10'h055},
    {12'h099, 10'h05F}, {12'h555, 10'h2D5}, {12'h999, 10'h0FF},
    {12'h800, 10'h00C}, {12'h980, 10'h08E}, {12'h123, 10'h0A3}};

  always @(negedge clk) begin
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = ~out_ready;
      default: out_ready = 1'b0;
    endcase
  end

  always @(negedge clk) begin
    #4;
    if (!rst && out_valid && out_ready) got_q.push_back(out_data);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [7:0] b, input logic e);
    bit done = 0;
    @(negedge clk);
    in_valid = v; in_byte = b; in_eom = e;
    while (!done) begin
      #4; done = in_ready;
      @(negedge clk);
    end
    in_valid = 1'b0; in_eom = 1'b0;
  endtask

  task automatic drain();
    bit idle = 0;
    while (!idle) begin @(negedge clk); #4; idle = in_ready; end
    repeat (40) @(negedge clk);
  endtask

  task automatic model(input string s);
    int dig[$];
    bit bits[$];
    exp_q.delete();
    for (int n = 0; n < s.len(); n++)
      if (s[n] >= "0" && s[n] <= "9") dig.push_back(int'(s[n]) - 48);
    for (int g = 0; g < dig.size(); g += 3) begin
      logic [11:0] b = '0;
      logic [9:0] d;
      for (int k = 0; k < 3; k++)
        b = {b[7:0], (g + k < dig.size()) ? 4'(dig[g + k]) : 4'd0};
      d = dpd_enc(b);
      for (int j = 9; j >= 0; j--) bits.push_back(d[j]);
    end
    while (bits.size() % 8 != 0) bits.push_back(1'b0);
    for (int y = 0; y < bits.size() / 8; y++) begin
      logic [7:0] v = '0;
      for (int z = 0; z < 8; z++) v = {v[6:0], bits[8 * y + z]};
      exp_q.push_back(v);
    end
  endtask

  task automatic compare(input string req);
    check(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    for (int n = 0; n < exp_q.size() && n < got_q.size(); n++)
      check(got_q[n] == exp_q[n], req, got_q[n], exp_q[n]);
  endtask

  task automatic run_msg(input string s, input string req);
    got_q.delete();
    for (int n = 0; n < s.len(); n++) drive(1'b1, s[n], 1'b0);
    drive(1'b0, 8'h00, 1'b1);
    drain();
    model(s);
    compare(req);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #4;
    check(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R10 in_ready", in_ready, 1);

    // table walk: R1 R2 R6 against known codes
    foreach (VEC[v]) begin
      logic [11:0] b = VEC[v][21:10];
      logic [9:0]  d = VEC[v][9:0];
      check(dpd_enc(b) == d, "R2 model", dpd_enc(b), d);
      got_q.delete();
      for (int k = 2; k >= 0; k--) drive(1'b1, 8'h30 + 8'(b[4*k +: 4]), 1'b0);
      drive(1'b0, 8'h00, 1'b1);
      drain();
      check(got_q.size() == 2, "R6 count", got_q.size(), 2);
      if (got_q.size() == 2) begin
        check(got_q[0] == d[9:2], "R1 R5 byte0", got_q[0], d[9:2]);
        check(got_q[1] == {d[1:0], 6'b0}, "R6 byte1", got_q[1], {d[1:0], 6'b0});
      end
    end

    run_msg("1x2 3", "R3 ignore");
    run_msg("7", "R4 one digit");
    run_msg("45", "R4 two digits");
    run_msg("123456789012", "R5 stream");
    check(got_q.size() == 5, "R5 no pad byte", got_q.size(), 5);
    run_msg("", "R6 empty message");
    run_msg("12", "R9 first");
    run_msg("3", "R9 fresh start");

    // stall: R7 R8
    rdy_mode = 2;
    got_q.delete();
    for (int n = 1; n <= 9; n++) drive(1'b1, 8'h30 + 8'(n), 1'b0);
    for (int n = 0; n < 10; n++) begin
      @(negedge clk); #4;
      check(in_ready == 1'b0, "R8 stall", in_ready, 0);
      check(out_valid && out_data == 8'h28, "R7 hold", out_data, 8'h28);
    end
    rdy_mode = 0;
    drive(1'b0, 8'h00, 1'b1);
    drain();
    model("123456789");
    compare("R7 R8 after stall");

    rdy_mode = 1;
    run_msg("9876543210", "R5 toggled ready");
    rdy_mode = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule